// File: doc/BRIEF.md
# Nonvolatile Memory Operation Control Register

This block is the control and status register that software uses to drive an on-chip nonvolatile store. A byte-wide register port with a write enable and a combinational read-back lets software pick the target space, arm writes, request a row erase and start one-cycle reads. Toward the store, the block produces a read strobe, a one-cycle start pulse for an erase or write, a two-bit space select and an erase flag. An internal self-timed counter measures how long each erase or write lasts.

The command bits can only be set by software. Hardware clears them: a read command clears itself after one cycle, and an erase/write command clears when its timer expires. That same expiry raises a done pulse and a sticky completion interrupt. A warm reset (external pin or watchdog) that lands during an erase/write cancels the operation. It sets an error flag and leaves the space and erase bits as they were, so software can see which operation failed. A power-on reset clears every bit.

Top module: `nvm_ctrl_reg`

## Requirements
- R1: After power-on reset the register reads 0x00, the space select is 0, and the read strobe, start pulse, erase flag, done pulse and interrupt are all 0.
- R2: While no erase/write is running, a bus write loads bit 7 (program space), bit 6 (configuration space), bit 4 (row erase), bit 3 (error) and bit 2 (write enable), and the value reads back at once. Bit 5 always reads 0.
- R3: The space select output is 2 when bit 6 is 1, whatever bit 7 holds. Otherwise it is 1 when bit 7 is 1, and 0 when both bits are 0.
- R4: Writing 1 to bit 1 while bit 2 already holds 1 and the block is idle starts an operation. Bit 1 then reads 1 for exactly OP_CYCLES cycles, starting the cycle after the write, and the start pulse is high for the first of those cycles only.
- R5: The done pulse is high in the last cycle of an operation. In the next cycle bit 1 and bit 4 read 0 and the interrupt output is 1. The interrupt stays 1 until the next operation starts.
- R6: A write of 1 to bit 1 has no effect when bit 2 holds 0 or an operation is already running. A write of 0 to bit 1 never clears it.
- R7: While an operation runs, writes to bits 7, 6, 4 and 3 are ignored. Bit 2 stays writable.
- R8: Writing 1 to bit 0 sets bit 0 and the read strobe for exactly one cycle, after which hardware clears them. Writing 0 to bit 0 has no effect.
- R9: A write of 1 to bit 0 is ignored while bit 7 holds 1 or an operation is running.
- R10: A warm reset clears bits 2, 1 and 0 and keeps bits 7, 6 and 4. It sets bit 3 if an operation was running, and otherwise leaves bit 3 unchanged. An operation cancelled this way produces no done pulse.
- R11: The erase flag output equals bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| warm_rst | input | 1 | Warm reset from the pin or the watchdog, synchronous, active high |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| mem_rd_strobe | output | 1 | One-cycle read request to the store |
| mem_wr_start | output | 1 | One-cycle erase/write start pulse |
| mem_space | output | 2 | Target space: 0 data, 1 program, 2 configuration |
| mem_erase | output | 1 | Row-erase flag for the running operation |
| op_done | output | 1 | Completion pulse of an erase/write |
| op_irq | output | 1 | Sticky completion interrupt |

## Verification
The assertions check on every cycle the rules that relate one cycle to the next. A started operation must have had its enable set. The read bit and the start pulse last one cycle. A read never begins with program space selected. The mode bits stay frozen while an operation runs. The internal timer tracks the busy bit. A warm reset during an operation leaves the error flag set. Exact lengths and values need the bench's scenarios: the busy window of exactly OP_CYCLES cycles, the read-back of each bit pattern, the override of space selection, the clearing of the erase bit on completion, and the register contents kept or cleared by warm resets arriving while busy or while idle.

// File: rtl/nvm_csr_pkg.sv
package nvm_csr_pkg;

   localparam int unsigned CSR_W     = 8;
   localparam int unsigned B_PROG    = 7;
   localparam int unsigned B_CFG     = 6;
   localparam int unsigned B_RSV     = 5;
   localparam int unsigned B_ERASE   = 4;
   localparam int unsigned B_ERR     = 3;
   localparam int unsigned B_WREN    = 2;
   localparam int unsigned B_WRGO    = 1;
   localparam int unsigned B_RDGO    = 0;

   typedef enum logic [1:0] {
      SPACE_DATA = 2'd0,
      SPACE_PROG = 2'd1,
      SPACE_CFG  = 2'd2
   } nvm_space_e;

   typedef struct packed {
      logic prog;
      logic cfg;
      logic erase;
      logic err;
      logic wren;
      logic wrgo;
      logic rdgo;
   } csr_t;

endpackage

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
   parameter int unsigned OP_CYCLES = 16
) (
   input  logic clk,
   input  logic por_n,
   input  logic start_i,
   input  logic abort_i,
   output logic running_o,
   output logic done_o
);

   localparam int unsigned CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;

   initial begin
      assert (OP_CYCLES >= 1)
         else $error("nvm_op_timer: OP_CYCLES must be at least 1");
   end

   logic run_q;

   generate
      if (OP_CYCLES == 1) begin : g_single
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)       run_q <= 1'b0;
            else if (abort_i) run_q <= 1'b0;
            else if (start_i) run_q <= 1'b1;
            else              run_q <= 1'b0;
         end
         assign done_o = run_q && !abort_i;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
               run_q <= 1'b0;
               cnt_q <= '0;
            end else if (abort_i) begin
               run_q <= 1'b0;
            end else if (start_i) begin
               run_q <= 1'b1;
               cnt_q <= CNT_W'(OP_CYCLES - 1);
            end else if (run_q) begin
               if (cnt_q == '0) run_q <= 1'b0;
               else             cnt_q <= cnt_q - 1'b1;
            end
         end
         assign done_o = run_q && (cnt_q == '0) && !abort_i;

         p_start_runs_r4: assert property (@(posedge clk) disable iff (!por_n)
            (start_i && !abort_i) |=> run_q);
      end
   endgenerate

   assign running_o = run_q;

endmodule

// File: rtl/nvm_space_decode.sv
module nvm_space_decode
   import nvm_csr_pkg::*;
(
   input  logic       prog_i,
   input  logic       cfg_i,
   output nvm_space_e space_o
);

   always_comb begin
      if (cfg_i)       space_o = SPACE_CFG;
      else if (prog_i) space_o = SPACE_PROG;
      else             space_o = SPACE_DATA;
   end

endmodule

// File: rtl/nvm_csr_core.sv
module nvm_csr_core
   import nvm_csr_pkg::*;
(
   input  logic             clk,
   input  logic             por_n,
   input  logic             warm_rst_i,
   input  logic             we_i,
   input  logic [CSR_W-1:0] wdata_i,
   input  logic             done_i,
   output csr_t             csr_o,
   output logic             start_o,
   output logic             start_pulse_o,
   output logic             irq_o
);

   csr_t csr_q;
   logic start_q;
   logic irq_q;
   logic rd_req;
   logic unused_rsv;

   assign unused_rsv = wdata_i[B_RSV];

   assign start_o = we_i && wdata_i[B_WRGO] && csr_q.wren && !csr_q.wrgo && !warm_rst_i;
   assign rd_req  = we_i && wdata_i[B_RDGO] && !csr_q.prog && !csr_q.wrgo && !csr_q.rdgo;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         csr_q   <= '0;
         start_q <= 1'b0;
         irq_q   <= 1'b0;
      end else if (warm_rst_i) begin
         csr_q.wren <= 1'b0;
         csr_q.wrgo <= 1'b0;
         csr_q.rdgo <= 1'b0;
         if (csr_q.wrgo) csr_q.err <= 1'b1;
         start_q <= 1'b0;
      end else begin
         csr_q.rdgo <= rd_req;
         start_q    <= start_o;
         if (done_i) begin
            csr_q.wrgo  <= 1'b0;
            csr_q.erase <= 1'b0;
            irq_q       <= 1'b1;
         end
         if (we_i) begin
            if (!csr_q.wrgo) begin
               csr_q.prog  <= wdata_i[B_PROG];
               csr_q.cfg   <= wdata_i[B_CFG];
               csr_q.erase <= wdata_i[B_ERASE];
               csr_q.err   <= wdata_i[B_ERR];
            end
            csr_q.wren <= wdata_i[B_WREN];
         end
         if (start_o) begin
            csr_q.wrgo <= 1'b1;
            irq_q      <= 1'b0;
         end
      end
   end

   assign csr_o         = csr_q;
   assign start_pulse_o = start_q;
   assign irq_o         = irq_q;

   p_go_needs_wren_r6: assert property (@(posedge clk) disable iff (!por_n)
      $rose(csr_q.wrgo) |-> $past(csr_q.wren));

   p_start_one_cycle_r4: assert property (@(posedge clk) disable iff (!por_n)
      start_q |=> !start_q);

   p_rd_one_cycle_r8: assert property (@(posedge clk) disable iff (!por_n)
      csr_q.rdgo |=> !csr_q.rdgo);

   p_rd_not_prog_r9: assert property (@(posedge clk) disable iff (!por_n)
      $rose(csr_q.rdgo) |-> !$past(csr_q.prog));

   p_mode_frozen_r7: assert property (@(posedge clk) disable iff (!por_n)
      (csr_q.wrgo && $past(csr_q.wrgo))
         |-> $stable({csr_q.prog, csr_q.cfg, csr_q.erase, csr_q.err}));

   p_abort_err_r10: assert property (@(posedge clk) disable iff (!por_n)
      (warm_rst_i && csr_q.wrgo) |=> (csr_q.err && !csr_q.wrgo));

   p_done_clears_r5: assert property (@(posedge clk) disable iff (!por_n)
      (done_i && !warm_rst_i) |=> (!csr_q.wrgo && !csr_q.erase && irq_q));

endmodule

// File: rtl/nvm_ctrl_reg.sv
module nvm_ctrl_reg
   import nvm_csr_pkg::*;
#(
   parameter int unsigned OP_CYCLES = 16
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       warm_rst,
   input  logic       reg_we,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       mem_rd_strobe,
   output logic       mem_wr_start,
   output logic [1:0] mem_space,
   output logic       mem_erase,
   output logic       op_done,
   output logic       op_irq
);

   initial begin
      assert (CSR_W == 8)
         else $error("nvm_ctrl_reg: register must be one byte wide");
   end

   csr_t       csr;
   logic       start;
   logic       tmr_running;
   logic       tmr_done;
   nvm_space_e space;

   nvm_csr_core u_core (
      .clk           (clk),
      .por_n         (por_n),
      .warm_rst_i    (warm_rst),
      .we_i          (reg_we),
      .wdata_i       (reg_wdata),
      .done_i        (tmr_done),
      .csr_o         (csr),
      .start_o       (start),
      .start_pulse_o (mem_wr_start),
      .irq_o         (op_irq)
   );

   nvm_op_timer #(.OP_CYCLES(OP_CYCLES)) u_timer (
      .clk       (clk),
      .por_n     (por_n),
      .start_i   (start),
      .abort_i   (warm_rst),
      .running_o (tmr_running),
      .done_o    (tmr_done)
   );

   nvm_space_decode u_space (
      .prog_i  (csr.prog),
      .cfg_i   (csr.cfg),
      .space_o (space)
   );

   assign reg_rdata = {csr.prog, csr.cfg, 1'b0, csr.erase,
                       csr.err, csr.wren, csr.wrgo, csr.rdgo};
   assign mem_rd_strobe = csr.rdgo;
   assign mem_space     = space;
   assign mem_erase     = csr.erase;
   assign op_done       = tmr_done;

   p_timer_tracks_busy_r4: assert property (@(posedge clk) disable iff (!por_n)
      tmr_running == csr.wrgo);

   p_done_only_busy_r5: assert property (@(posedge clk) disable iff (!por_n)
      op_done |-> csr.wrgo);

   p_pulse_while_busy_r4: assert property (@(posedge clk) disable iff (!por_n)
      mem_wr_start |-> csr.wrgo);

endmodule

// File: tb/nvm_ctrl_reg_bench.sv
module nvm_ctrl_reg_bench;

   localparam int OPC = 12;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       warm_rst = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       mem_rd_strobe, mem_wr_start, mem_erase, op_done, op_irq;
   logic [1:0] mem_space;

   nvm_ctrl_reg #(.OP_CYCLES(OPC)) u_nvm_ctrl_reg (
      .clk(clk), .por_n(por_n), .warm_rst(warm_rst),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_rd_strobe(mem_rd_strobe), .mem_wr_start(mem_wr_start),
      .mem_space(mem_space), .mem_erase(mem_erase),
      .op_done(op_done), .op_irq(op_irq)
   );

   always #4 clk = ~clk;

   typedef struct {
      int         at;
      int         sel;
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t q[$];
   int cyc = 0;
   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] observe(int sel);
      case (sel)
         0: return reg_rdata;
         1: return {7'd0, mem_wr_start};
         2: return {7'd0, mem_rd_strobe};
         3: return {6'd0, mem_space};
         4: return {7'd0, mem_erase};
         5: return {7'd0, op_done};
         default: return {7'd0, op_irq};
      endcase
   endfunction

   // Monitor: compare every expectation due in this cycle
   always @(negedge clk) begin
      for (int i = q.size() - 1; i >= 0; i--) begin
         if (q[i].at == cyc) begin
            checks++;
            if (observe(q[i].sel) !== q[i].exp) begin
               failures++;
               $display("FAIL %s sel=%0d cycle=%0d actual=%h expected=%h",
                        q[i].tag, q[i].sel, cyc, observe(q[i].sel), q[i].exp);
            end
            q.delete(i);
         end
      end
   end

   task automatic exp_at(int at, int sel, logic [7:0] v, string tag);
      item_t it;
      it.at = at; it.sel = sel; it.exp = v; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic wr_reg(logic [7:0] v);
      reg_we = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic warm_pulse();
      warm_rst = 1'b1;
      @(negedge clk);
      warm_rst = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int c0;
      idle(3);
      por_n = 1'b1;
      // R1 reset state
      exp_at(cyc + 1, 0, 8'h00, "R1");
      exp_at(cyc + 1, 3, 8'h00, "R1");
      exp_at(cyc + 1, 1, 8'h00, "R1");
      exp_at(cyc + 1, 2, 8'h00, "R1");
      exp_at(cyc + 1, 4, 8'h00, "R1");
      exp_at(cyc + 1, 5, 8'h00, "R1");
      exp_at(cyc + 1, 6, 8'h00, "R1");
      idle(2);

      // R2/R3 program space with enable
      exp_at(cyc + 1, 0, 8'h84, "R2");
      exp_at(cyc + 1, 3, 8'h01, "R3");
      wr_reg(8'h84);

      // R4 start, R6/R7 writes while busy, R5 completion
      c0 = cyc;
      exp_at(c0 + 1, 0, 8'h86, "R4");
      exp_at(c0 + 1, 1, 8'h01, "R4");
      exp_at(c0 + 1, 6, 8'h00, "R5");
      wr_reg(8'h86);
      exp_at(cyc + 1, 0, 8'h86, "R7");
      exp_at(cyc + 1, 1, 8'h00, "R6");
      wr_reg(8'hC6);
      exp_at(cyc + 1, 0, 8'h82, "R7");
      wr_reg(8'h80);
      exp_at(c0 + OPC - 1, 5, 8'h00, "R5");
      exp_at(c0 + OPC, 0, 8'h82, "R4");
      exp_at(c0 + OPC, 5, 8'h01, "R5");
      exp_at(c0 + OPC + 1, 0, 8'h80, "R5");
      exp_at(c0 + OPC + 1, 6, 8'h01, "R5");
      idle(OPC + 2);

      // R11 row erase, completion clears erase bit, R5 irq cleared on start
      exp_at(cyc + 1, 0, 8'h94, "R2");
      exp_at(cyc + 1, 4, 8'h01, "R11");
      wr_reg(8'h94);
      c0 = cyc;
      exp_at(c0 + 1, 1, 8'h01, "R4");
      exp_at(c0 + 1, 6, 8'h00, "R5");
      exp_at(c0 + OPC + 1, 0, 8'h84, "R5");
      exp_at(c0 + OPC + 1, 4, 8'h00, "R11");
      wr_reg(8'h96);
      idle(OPC + 2);

      // R6 go ignored without enable
      exp_at(cyc + 1, 0, 8'h80, "R2");
      wr_reg(8'h80);
      exp_at(cyc + 1, 0, 8'h80, "R6");
      exp_at(cyc + 1, 1, 8'h00, "R6");
      wr_reg(8'h82);

      // R9 read blocked in program space, R8 read in data space
      exp_at(cyc + 1, 0, 8'h80, "R9");
      exp_at(cyc + 1, 2, 8'h00, "R9");
      wr_reg(8'h81);
      exp_at(cyc + 1, 3, 8'h00, "R3");
      wr_reg(8'h00);
      exp_at(cyc + 1, 0, 8'h01, "R8");
      exp_at(cyc + 1, 2, 8'h01, "R8");
      exp_at(cyc + 2, 0, 8'h00, "R8");
      exp_at(cyc + 2, 2, 8'h00, "R8");
      wr_reg(8'h01);
      idle(2);

      // R3 configuration override, R2 reserved bit
      exp_at(cyc + 1, 3, 8'h02, "R3");
      wr_reg(8'h44);
      exp_at(cyc + 1, 0, 8'hC4, "R2");
      exp_at(cyc + 1, 3, 8'h02, "R3");
      wr_reg(8'hC4);
      exp_at(cyc + 1, 0, 8'h00, "R2");
      wr_reg(8'h20);
      exp_at(cyc + 1, 0, 8'hDC, "R2");
      wr_reg(8'hFC);
      wr_reg(8'h00);

      // R10 warm reset during an erase
      wr_reg(8'h94);
      c0 = cyc;
      wr_reg(8'h96);
      idle(3);
      exp_at(cyc + 1, 0, 8'h98, "R10");
      warm_pulse();
      exp_at(c0 + OPC, 5, 8'h00, "R10");
      exp_at(c0 + OPC + 1, 0, 8'h98, "R10");
      idle(OPC + 2);

      // R10 warm reset while idle
      exp_at(cyc + 1, 0, 8'h84, "R2");
      wr_reg(8'h84);
      exp_at(cyc + 1, 0, 8'h80, "R10");
      warm_pulse();
      wr_reg(8'h8C);
      exp_at(cyc + 1, 0, 8'h88, "R10");
      warm_pulse();
      idle(3);

      if (q.size() != 0) begin
         failures++;
         $display("FAIL scoreboard left %0d pending items actual=%0d expected=0",
                  q.size(), q.size());
      end
      finish_run();
   end

endmodule